// File: doc/BRIEF.md
# Masked Interrupt Register Unit

This unit holds the interrupt bookkeeping of one peripheral function block. Internal event logic hands it two 32-bit vectors each cycle: bits to raise and bits to drop. It keeps them in a pending register. A second register enables individual bits. The logical AND of the two is the masked view, and the single level interrupt line is high whenever any bit of that view is set.

Software reaches four registers over a simple register bus. The pending register can be read and written. The enable register can be read and written. The acknowledge register is write-one-to-drop and reads as zero. The masked view is read-only. The offset of each register within the block is a parameter.

A second port gives debug access for checkpoint save and restore. It reads and writes the stored pending and enable words directly and never produces a notification. A one-cycle change pulse marks every cycle in which the interrupt line first shows a new level, except when a debug write caused the new level.

Top module: `irq_regblock`

## Requirements
- R1: A synchronous active-high reset sets the pending and enable registers to zero. After reset the interrupt line and the change pulse are low.
- R2: A bus write at offset OFF_PEND loads the pending register. A bus read at that offset returns the pending register.
- R3: A bus write at offset OFF_ENA loads the enable register. A bus read at that offset returns the enable register.
- R4: A bus read at offset OFF_VIEW returns pending AND enable. Bus writes to OFF_VIEW change no register.
- R5: A bus write at offset OFF_ACK drops every pending bit whose written bit is 1 and leaves the bits written as 0 unchanged. A read at OFF_ACK returns 0.
- R6: The interrupt line is high exactly when pending AND enable is non-zero. It follows the register contents one clock after a write or an event.
- R7: Each bit set in the raise vector sets the matching pending bit. Each bit set in the drop vector clears it. Both take effect at the next clock edge.
- R8: When a raise and a drop hit the same bit in the same cycle, the raise wins. The drop may come from the drop vector or from a bus write at OFF_ACK. A bus write at OFF_PEND in the same cycle supplies the base value, and the drops and raises are then applied to it.
- R9: The change pulse is high for exactly one cycle, in the first cycle in which the interrupt line shows a new level. This includes level changes caused by enable writes. It stays low when a raise hits an already pending bit or a drop hits an already clear bit.
- R10: The debug port reads the same values as the bus at every offset. A debug write to OFF_PEND or OFF_ENA stores the data directly, wins over any same-cycle bus write or event for that register, and never raises the change pulse. Debug writes to OFF_ACK or OFF_VIEW have no effect.
- R11: Reads at any offset other than the four register offsets return 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus register offset, for reads and writes |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from bus_addr |
| dbg_addr | input | ADDR_W | Debug port register offset |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, combinational from dbg_addr |
| evt_raise | input | 32 | Bits to set in the pending register this cycle |
| evt_drop | input | 32 | Bits to clear in the pending register this cycle |
| irq_out | output | 1 | Level interrupt output |
| irq_changed | output | 1 | One-cycle pulse when irq_out takes a new level |

## Verification
The embedded assertions check the following on every cycle:
- A raise is visible in the pending register one cycle later, including when it competes with a drop.
- A dropped bit that was not also raised is gone one cycle later.
- Both registers hold their value when no write or event targets them, which covers writes to the read-only view.
- The change pulse agrees with actual flips of the interrupt line, in both directions.

Only the directed scenarios can show the remaining behaviour:
- The register values seen through the read mux at each offset.
- Write-one-to-drop behaviour and the zero readback of the acknowledge offset.
- Zero reads at unmapped offsets.
- The debug port overriding a same-cycle event while staying silent.

// File: rtl/irq_regblock_pkg.sv
package irq_regblock_pkg;

    localparam int REG_W = 32;

    typedef logic [REG_W-1:0] reg_word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ACK,
        SEL_ENA,
        SEL_VIEW
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e  sel;
        logic      we;
        reg_word_t data;
    } reg_access_t;

    // Drops are applied first and raises last, so a raise is never lost.
    function automatic reg_word_t apply_events(reg_word_t base, reg_word_t drop, reg_word_t raise);
        return (base & ~drop) | raise;
    endfunction

    function automatic reg_word_t read_word(reg_sel_e sel, reg_word_t pend, reg_word_t ena);
        reg_word_t r;
        case (sel)
            SEL_PEND: r = pend;
            SEL_ENA:  r = ena;
            SEL_VIEW: r = pend & ena;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic writes_to(reg_access_t a, reg_sel_e s);
        return a.we && (a.sel == s);
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regblock_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFF_PEND = 'h020,
    parameter logic [ADDR_W-1:0] OFF_ACK  = 'h024,
    parameter logic [ADDR_W-1:0] OFF_ENA  = 'h028,
    parameter logic [ADDR_W-1:0] OFF_VIEW = 'h02C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  reg_word_t         wdata,
    output reg_access_t       acc
);

    reg_sel_e sel;

    always_comb begin
        if (addr == OFF_PEND)      sel = SEL_PEND;
        else if (addr == OFF_ACK)  sel = SEL_ACK;
        else if (addr == OFF_ENA)  sel = SEL_ENA;
        else if (addr == OFF_VIEW) sel = SEL_VIEW;
        else                       sel = SEL_NONE;
    end

    assign acc = '{sel: sel, we: we, data: wdata};

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
    import irq_regblock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reg_access_t bus_acc,
    input  reg_access_t dbg_acc,
    input  reg_word_t   evt_raise,
    input  reg_word_t   evt_drop,
    output reg_word_t   pend_q,
    output reg_word_t   ena_q,
    output reg_word_t   pend_d,
    output reg_word_t   ena_d,
    output logic        quiet
);

    reg_word_t pend_base;
    reg_word_t drop_vec;
    logic      dbg_pend_wr;
    logic      dbg_ena_wr;

    assign dbg_pend_wr = writes_to(dbg_acc, SEL_PEND);
    assign dbg_ena_wr  = writes_to(dbg_acc, SEL_ENA);
    assign quiet       = dbg_pend_wr || dbg_ena_wr;

    always_comb begin
        pend_base = writes_to(bus_acc, SEL_PEND) ? bus_acc.data : pend_q;
        drop_vec  = evt_drop | (writes_to(bus_acc, SEL_ACK) ? bus_acc.data : '0);
        pend_d    = apply_events(pend_base, drop_vec, evt_raise);
        if (dbg_pend_wr) pend_d = dbg_acc.data;

        ena_d = ena_q;
        if (writes_to(bus_acc, SEL_ENA)) ena_d = bus_acc.data;
        if (dbg_ena_wr)                  ena_d = dbg_acc.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ena_q  <= '0;
        end else begin
            pend_q <= pend_d;
            ena_q  <= ena_d;
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_q == '0) && (ena_q == '0)); // R1

    AST_RAISE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (|evt_raise) && !dbg_pend_wr |=> ((pend_q & $past(evt_raise)) == $past(evt_raise))); // R8

    AST_DROP_LANDS: assert property (@(posedge clk) disable iff (rst)
        (|evt_drop) && !dbg_pend_wr && !writes_to(bus_acc, SEL_PEND)
        |=> ((pend_q & $past(evt_drop & ~evt_raise)) == '0)); // R7

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt_raise == '0) && (evt_drop == '0) && !quiet
        && !writes_to(bus_acc, SEL_PEND) && !writes_to(bus_acc, SEL_ACK)
        && !writes_to(bus_acc, SEL_ENA)
        |=> $stable(pend_q) && $stable(ena_q)); // R4

endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import irq_regblock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_word_t pend_q,
    input  reg_word_t ena_q,
    input  reg_word_t pend_d,
    input  reg_word_t ena_d,
    input  logic      quiet,
    output logic      irq_out,
    output logic      irq_changed
);

    logic level_now;
    logic level_next;
    logic chg_q;
    logic quiet_q;

    assign level_now  = |(pend_q & ena_q);
    assign level_next = |(pend_d & ena_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            chg_q   <= 1'b0;
            quiet_q <= 1'b0;
        end else begin
            chg_q   <= (level_next != level_now) && !quiet;
            quiet_q <= quiet;
        end
    end

    assign irq_out     = level_now;
    assign irq_changed = chg_q;

    AST_PULSE_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
        irq_changed |-> (irq_out != $past(irq_out))); // R9

    AST_FLIP_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
        (irq_out != $past(irq_out)) && !quiet_q |-> irq_changed); // R9

    AST_NO_PULSE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq_changed && !irq_out); // R1

endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
    import irq_regblock_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFF_PEND = 'h020,
    parameter logic [ADDR_W-1:0] OFF_ACK  = 'h024,
    parameter logic [ADDR_W-1:0] OFF_ENA  = 'h028,
    parameter logic [ADDR_W-1:0] OFF_VIEW = 'h02C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_we,
    input  logic [REG_W-1:0]  dbg_wdata,
    output logic [REG_W-1:0]  dbg_rdata,
    input  logic [REG_W-1:0]  evt_raise,
    input  logic [REG_W-1:0]  evt_drop,
    output logic              irq_out,
    output logic              irq_changed
);

    localparam int NPORT = 2;
    localparam int P_BUS = 0;
    localparam int P_DBG = 1;

    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic              p_we    [NPORT];
    reg_word_t         p_wdata [NPORT];
    reg_access_t       p_acc   [NPORT];
    reg_word_t         p_rdata [NPORT];

    reg_word_t pend_q, ena_q, pend_d, ena_d;
    logic      quiet;

    assign p_addr[P_BUS]  = bus_addr;
    assign p_we[P_BUS]    = bus_we;
    assign p_wdata[P_BUS] = bus_wdata;
    assign p_addr[P_DBG]  = dbg_addr;
    assign p_we[P_DBG]    = dbg_we;
    assign p_wdata[P_DBG] = dbg_wdata;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        irq_addr_decode #(
            .ADDR_W(ADDR_W), .OFF_PEND(OFF_PEND), .OFF_ACK(OFF_ACK),
            .OFF_ENA(OFF_ENA), .OFF_VIEW(OFF_VIEW)
        ) u_dec (
            .addr (p_addr[g]),
            .we   (p_we[g]),
            .wdata(p_wdata[g]),
            .acc  (p_acc[g])
        );
        assign p_rdata[g] = read_word(p_acc[g].sel, pend_q, ena_q);
    end

    irq_state_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_acc  (p_acc[P_BUS]),
        .dbg_acc  (p_acc[P_DBG]),
        .evt_raise(evt_raise),
        .evt_drop (evt_drop),
        .pend_q   (pend_q),
        .ena_q    (ena_q),
        .pend_d   (pend_d),
        .ena_d    (ena_d),
        .quiet    (quiet)
    );

    irq_combine u_comb (
        .clk        (clk),
        .rst        (rst),
        .pend_q     (pend_q),
        .ena_q      (ena_q),
        .pend_d     (pend_d),
        .ena_d      (ena_d),
        .quiet      (quiet),
        .irq_out    (irq_out),
        .irq_changed(irq_changed)
    );

    assign bus_rdata = p_rdata[P_BUS];
    assign dbg_rdata = p_rdata[P_DBG];

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == dbg_addr) |-> (bus_rdata == dbg_rdata)); // R10

    AST_LINE_MATCHES_VIEW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_VIEW) |-> (irq_out == (bus_rdata != '0))); // R6

endmodule

// File: tb/irq_regblock_test.sv
module irq_regblock_test;
    import irq_regblock_pkg::*;

    localparam logic [11:0] A_PEND = 12'h020;
    localparam logic [11:0] A_ACK  = 12'h024;
    localparam logic [11:0] A_ENA  = 12'h028;
    localparam logic [11:0] A_VIEW = 12'h02C;
    localparam logic [11:0] A_HOLE = 12'h000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] dbg_addr = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] evt_raise = '0;
    logic [31:0] evt_drop = '0;
    logic        irq_out;
    logic        irq_changed;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_regblock uut (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .evt_raise(evt_raise), .evt_drop(evt_drop),
        .irq_out(irq_out), .irq_changed(irq_changed)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bwrite(logic [11:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic bread(logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic dwrite(logic [11:0] a, logic [31:0] d);
        dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
        tick();
        dbg_we = 1'b0;
    endtask

    task automatic dread(logic [11:0] a, output logic [31:0] d);
        dbg_addr = a; #1; d = dbg_rdata;
    endtask

    task automatic events(logic [31:0] r, logic [31:0] c);
        evt_raise = r; evt_drop = c;
        tick();
        evt_raise = '0; evt_drop = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bread(A_PEND, v); chk("R1 pend", v, 0);
        bread(A_ENA, v);  chk("R1 ena", v, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 chg", {31'b0, irq_changed}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bwrite(A_PEND, 32'hA5A5_0001);
        chk("R9 no pulse, mask zero", {31'b0, irq_changed}, 0);
        bread(A_PEND, v); chk("R2 pend readback", v, 32'hA5A5_0001);
        bwrite(A_ENA, 32'h0000_FFFF);
        chk("R9 pulse on enable", {31'b0, irq_changed}, 1);
        chk("R6 irq high", {31'b0, irq_out}, 1);
        bread(A_ENA, v); chk("R3 ena readback", v, 32'h0000_FFFF);
        bread(A_VIEW, v); chk("R4 view", v, 32'h0000_0001);
        tick();
        chk("R9 pulse one cycle", {31'b0, irq_changed}, 0);
        bwrite(A_VIEW, 32'hFFFF_FFFF);
        bread(A_VIEW, v); chk("R4 view write ignored", v, 32'h0000_0001);
        bread(A_PEND, v); chk("R4 pend untouched", v, 32'hA5A5_0001);
        bread(A_HOLE, v); chk("R11 bus hole", v, 0);
        dread(A_HOLE, v); chk("R11 dbg hole", v, 0);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        bwrite(A_ACK, 32'h0000_0001);
        chk("R5 irq dropped", {31'b0, irq_out}, 0);
        chk("R9 pulse on drop", {31'b0, irq_changed}, 1);
        bread(A_PEND, v); chk("R5 bit gone", v, 32'hA5A5_0000);
        bwrite(A_ACK, 32'h0000_0000);
        bread(A_PEND, v); chk("R5 zero write no effect", v, 32'hA5A5_0000);
        bread(A_ACK, v); chk("R5 ack reads zero", v, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        bwrite(A_PEND, 32'h0);
        bwrite(A_ENA, 32'h0000_00FF);
        events(32'h3, 32'h0);
        bread(A_PEND, v); chk("R7 raise", v, 32'h3);
        chk("R9 pulse raise", {31'b0, irq_changed}, 1);
        events(32'h1, 32'h0);
        chk("R9 repeat raise silent", {31'b0, irq_changed}, 0);
        events(32'h0, 32'h4);
        chk("R9 drop of clear bit silent", {31'b0, irq_changed}, 0);
        events(32'h0, 32'h3);
        bread(A_PEND, v); chk("R7 drop", v, 32'h0);
        chk("R6 irq low", {31'b0, irq_out}, 0);
        chk("R9 pulse drop", {31'b0, irq_changed}, 1);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        events(32'h10, 32'h10);
        bread(A_PEND, v); chk("R8 raise beats drop", v, 32'h10);
        evt_raise = 32'h20;
        bwrite(A_ACK, 32'h30);
        evt_raise = '0;
        bread(A_PEND, v); chk("R8 raise beats bus ack", v, 32'h20);
        evt_raise = 32'h01;
        bwrite(A_PEND, 32'h0000_0100);
        evt_raise = '0;
        bread(A_PEND, v); chk("R8 bus write then raise", v, 32'h101);
    endtask

    task automatic t_debug();
        logic [31:0] v;
        bwrite(A_PEND, 32'h0);
        tick();
        dwrite(A_PEND, 32'h0F);
        chk("R10 irq follows dbg", {31'b0, irq_out}, 1);
        chk("R10 dbg silent", {31'b0, irq_changed}, 0);
        dread(A_PEND, v); chk("R10 dbg read", v, 32'h0F);
        dwrite(A_ACK, 32'hFFFF_FFFF);
        dread(A_PEND, v); chk("R10 dbg ack ignored", v, 32'h0F);
        dwrite(A_VIEW, 32'h0);
        dread(A_VIEW, v); chk("R10 dbg view ignored", v, 32'h0F);
        evt_raise = 32'h100;
        dwrite(A_PEND, 32'h1);
        evt_raise = '0;
        bread(A_PEND, v); chk("R10 dbg beats event", v, 32'h1);
        dwrite(A_ENA, 32'h0);
        chk("R10 dbg enable silent", {31'b0, irq_changed}, 0);
        bread(A_ENA, v); chk("R10 dbg enable stored", v, 32'h0);
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_regs();
        t_ack();
        t_events();
        t_priority();
        t_debug();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule